// File: doc/BRIEF.md
# ECC Memory Controller Register File

This block is the software-visible control and status register set of an ECC memory controller. It presents nine 32-bit word registers on a simple memory-mapped port: a control register, a timing register, a fault status register, a video setup register, two fault address registers, a diagnostic register and two event counters. A parameter selects one of three implementations. The implementation decides which control bits can be written, which control bits survive a reset, and whether a small byte-wide diagnostic window exists.

A side port from the memory datapath delivers captured faults. Each capture loads the fault status register and both fault address registers. It raises a level interrupt when the fault is uncorrectable, or when it is correctable and correctable-error interrupts are enabled. Software clears the interrupt by writing the fault status register.

Register index N sits at byte address 4*N. The order is: control (0), timing (1), fault status (2), video (3), fault address low (4), fault address high (5), diagnostic (6), event counter 0 (7), event counter 1 (8).

Top module: `ecc_ctl_regs`

## Requirements
- R1: A control register write stores the data masked with 0x103 for implementation 0, and with 0xBFF for implementations 1 and 2. Bits 31:28 read back the implementation code and cannot be written. Bits 27:12 read as zero.
- R2: Reset clears the control bits that are not retained. Implementation 0 retains bit 8. Implementations 1 and 2 retain bits 9:2 and bit 11.
- R3: A timing register write stores the data with bit 31 forced to zero. Reset sets the timing register to 0x00000020.
- R4: Reset sets fault address low to 0x07C00000. Reset clears fault status, video, fault address high, diagnostic, both event counters and the interrupt.
- R5: A word write to fault status stores all 32 bits and deasserts irq on the next clock edge.
- R6: A pulse on flt_load copies flt_status, flt_addr_lo and flt_addr_hi into fault status, fault address low and fault address high. In the same cycle, a capture takes precedence over a bus write to fault status.
- R7: A capture with flt_status bit 3 (uncorrectable) set always asserts irq. A capture with only bit 0 (correctable) set asserts irq only when control bit 1 is set.
- R8: The bus cannot write the fault address registers. Indexes 9 and above ignore writes and read as zero.
- R9: The main window acts only on 32-bit accesses (bus_word=1) with bus_addr[1:0]=0. Other accesses write nothing and read zero.
- R10: Event counter 1 is written and read independently of event counter 0.
- R11: Implementation 0 has a 4-byte diagnostic window selected by diag_sel. A byte access (bus_word=0) writes wdata[7:0] to the byte at bus_addr[1:0] and reads that byte zero-extended. Word accesses to the window are ignored.
- R12: In implementations 1 and 2 the diagnostic window ignores writes and reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Selects the main register window |
| diag_sel | input | 1 | Selects the diagnostic byte window |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_addr | input | ADDR_W | Byte address within the selected window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| flt_load | input | 1 | Fault capture strobe |
| flt_status | input | 32 | Captured fault status (bit 0 correctable, bit 3 uncorrectable) |
| flt_addr_lo | input | 32 | Captured fault address, low word |
| flt_addr_hi | input | 32 | Captured fault address, high word |
| irq | output | 1 | Level interrupt |

## Verification
Most corrupted control bits show up on the very next read of the control register. A corrupted bit 1 also shows up as a missing or extra interrupt on the first correctable capture. A retention flop that loses its value appears only after the next reset, so the bench sets every control bit before pulsing reset. A stuck interrupt flop shows one cycle after a fault status write, because irq is registered. A fault address register that takes bus writes shows on its next read back, which must still return the reset or captured value.

// File: rtl/ecc_regs_pkg.sv
package ecc_regs_pkg;

  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NUM_REGS   = 9;
  localparam int unsigned CTL_W      = 12;
  localparam int unsigned DIAG_BYTES = 4;

  typedef enum logic [3:0] {
    REG_ENABLE   = 4'd0,
    REG_TIMING   = 4'd1,
    REG_FSTAT    = 4'd2,
    REG_VIDEO    = 4'd3,
    REG_FADDR_LO = 4'd4,
    REG_FADDR_HI = 4'd5,
    REG_DIAG     = 4'd6,
    REG_EVCNT0   = 4'd7,
    REG_EVCNT1   = 4'd8
  } reg_ix_e;

  localparam logic [DATA_W-1:0] TIMING_WMASK = 32'h7FFF_FFFF;
  localparam logic [DATA_W-1:0] TIMING_RST   = 32'h0000_0020;
  localparam logic [DATA_W-1:0] FADDR_LO_RST = 32'h07C0_0000;

  localparam int unsigned FS_CE_BIT     = 0;
  localparam int unsigned FS_UE_BIT     = 3;
  localparam int unsigned CTL_CEIRQ_BIT = 1;

  function automatic logic [CTL_W-1:0] ctl_wmask(input int impl);
    return (impl == 0) ? 12'h103 : 12'hBFF;
  endfunction

  function automatic logic [CTL_W-1:0] ctl_keep(input int impl);
    return (impl == 0) ? 12'h100 : 12'hBFC;
  endfunction

endpackage

// File: rtl/ecc_bus_decode.sv
module ecc_bus_decode
  import ecc_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  output logic              rd_hit,
  output logic [ADDR_W-3:0] rd_ix,
  output logic              wr_ctl,
  output logic              wr_tim,
  output logic              wr_fst,
  output logic              wr_vid,
  output logic              wr_dia,
  output logic              wr_ev0,
  output logic              wr_ev1
);
  localparam int unsigned IXW = ADDR_W - 2;

  logic [IXW-1:0] ix;
  logic           acc_ok;
  logic           wr_ok;

  assign ix     = bus_addr[ADDR_W-1:2];
  assign acc_ok = bus_sel && bus_word && (bus_addr[1:0] == 2'b00) &&
                  (ix < IXW'(NUM_REGS));
  assign wr_ok  = acc_ok && bus_we;

  assign rd_hit = acc_ok;
  assign rd_ix  = ix;

  assign wr_ctl = wr_ok && (ix == IXW'(REG_ENABLE));
  assign wr_tim = wr_ok && (ix == IXW'(REG_TIMING));
  assign wr_fst = wr_ok && (ix == IXW'(REG_FSTAT));
  assign wr_vid = wr_ok && (ix == IXW'(REG_VIDEO));
  assign wr_dia = wr_ok && (ix == IXW'(REG_DIAG));
  assign wr_ev0 = wr_ok && (ix == IXW'(REG_EVCNT0));
  assign wr_ev1 = wr_ok && (ix == IXW'(REG_EVCNT1));
endmodule

// File: rtl/ecc_ctl_reg.sv
module ecc_ctl_reg
  import ecc_regs_pkg::*;
#(
  parameter int IMPL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl_q
);
  localparam logic [CTL_W-1:0] WMASK = ctl_wmask(IMPL);
  localparam logic [CTL_W-1:0] KEEP  = ctl_keep(IMPL);

  for (genvar b = 0; b < CTL_W; b++) begin : g_bit
    if (!WMASK[b]) begin : g_const
      assign ctl_q[b] = 1'b0;
    end else if (KEEP[b]) begin : g_keep
      logic keep_d;
      logic keep_q;
      always_comb begin
        keep_d = keep_q;
        if (wr_en && rst_n) keep_d = wdata[b];
      end
      always_ff @(posedge clk) keep_q <= keep_d;
      assign ctl_q[b] = keep_q;
    end else begin : g_clr
      logic clr_d;
      logic clr_q;
      always_comb begin
        clr_d = clr_q;
        if (wr_en) clr_d = wdata[b];
      end
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= clr_d;
      assign ctl_q[b] = clr_q;
    end
  end

  assert_ctl_mask_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ctl_q == ($past(wdata) & WMASK));
endmodule

// File: rtl/ecc_irq_ctl.sv
module ecc_irq_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic flt_load,
  input  logic flt_ce,
  input  logic flt_ue,
  input  logic ce_irq_en,
  input  logic fst_wr,
  output logic irq
);
  logic raise;
  logic irq_d;
  logic irq_q;

  assign raise = flt_load && (flt_ue || (flt_ce && ce_irq_en));

  always_comb begin
    irq_d = irq_q;
    if (raise)       irq_d = 1'b1;
    else if (fst_wr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;

  assign irq = irq_q;

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fst_wr && !flt_load) |=> !irq);
  assert_ue_raise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_load && flt_ue) |=> irq);
  assert_ce_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_load && !flt_ue && !ce_irq_en && !irq && !fst_wr) |=> !irq);
endmodule

// File: rtl/ecc_diag_win.sv
module ecc_diag_win
  import ecc_regs_pkg::*;
#(
  parameter int          IMPL   = 0,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              diag_sel,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned SELW = $clog2(DIAG_BYTES);

  if (IMPL == 0) begin : g_win
    logic [7:0]      mem_q [DIAG_BYTES];
    logic [7:0]      mem_d [DIAG_BYTES];
    logic [SELW-1:0] sel;
    logic            byte_acc;
    logic            wr;

    assign sel      = bus_addr[SELW-1:0];
    assign byte_acc = diag_sel && !bus_word;
    assign wr       = byte_acc && bus_we;

    always_comb begin
      mem_d = mem_q;
      if (wr) mem_d[sel] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        for (int i = 0; i < DIAG_BYTES; i++) mem_q[i] <= 8'h00;
      end else begin
        mem_q <= mem_d;
      end

    assign rdata = byte_acc ? {{(DATA_W-8){1'b0}}, mem_q[sel]} : '0;

    logic unused_hi_addr;
    assign unused_hi_addr = ^bus_addr[ADDR_W-1:SELW];

    assert_diag_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> mem_q[$past(sel)] == $past(wdata));
  end else begin : g_none
    assign rdata = '0;
    logic unused_diag;
    assign unused_diag = ^{clk, rst_n, diag_sel, bus_we, bus_word, bus_addr, wdata};
  end
endmodule

// File: rtl/ecc_ctl_regs.sv
module ecc_ctl_regs
  import ecc_regs_pkg::*;
#(
  parameter int          IMPL   = 0,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              diag_sel,
  input  logic              bus_we,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              flt_load,
  input  logic [31:0]       flt_status,
  input  logic [31:0]       flt_addr_lo,
  input  logic [31:0]       flt_addr_hi,
  output logic              irq
);
  localparam int unsigned IXW = ADDR_W - 2;

  logic           rd_hit;
  logic [IXW-1:0] rd_ix;
  logic wr_ctl, wr_tim, wr_fst, wr_vid, wr_dia, wr_ev0, wr_ev1;

  ecc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel (bus_sel),
    .bus_we  (bus_we),
    .bus_word(bus_word),
    .bus_addr(bus_addr),
    .rd_hit  (rd_hit),
    .rd_ix   (rd_ix),
    .wr_ctl  (wr_ctl),
    .wr_tim  (wr_tim),
    .wr_fst  (wr_fst),
    .wr_vid  (wr_vid),
    .wr_dia  (wr_dia),
    .wr_ev0  (wr_ev0),
    .wr_ev1  (wr_ev1)
  );

  logic [CTL_W-1:0] ctl_q;

  ecc_ctl_reg #(.IMPL(IMPL)) u_ctl (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr_ctl),
    .wdata(bus_wdata[CTL_W-1:0]),
    .ctl_q(ctl_q)
  );

  ecc_irq_ctl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt_load (flt_load),
    .flt_ce   (flt_status[FS_CE_BIT]),
    .flt_ue   (flt_status[FS_UE_BIT]),
    .ce_irq_en(ctl_q[CTL_CEIRQ_BIT]),
    .fst_wr   (wr_fst),
    .irq      (irq)
  );

  logic [DATA_W-1:0] diag_rdata;

  ecc_diag_win #(.IMPL(IMPL), .ADDR_W(ADDR_W)) u_diag (
    .clk     (clk),
    .rst_n   (rst_n),
    .diag_sel(diag_sel),
    .bus_we  (bus_we),
    .bus_word(bus_word),
    .bus_addr(bus_addr),
    .wdata   (bus_wdata[7:0]),
    .rdata   (diag_rdata)
  );

  // Plain word registers: next-state logic
  logic [DATA_W-1:0] tim_d, fst_d, vid_d, flo_d, fhi_d, dia_d, ev0_d, ev1_d;
  logic [DATA_W-1:0] tim_q, fst_q, vid_q, flo_q, fhi_q, dia_q, ev0_q, ev1_q;

  always_comb begin
    tim_d = tim_q;
    fst_d = fst_q;
    vid_d = vid_q;
    flo_d = flo_q;
    fhi_d = fhi_q;
    dia_d = dia_q;
    ev0_d = ev0_q;
    ev1_d = ev1_q;
    if (wr_tim) tim_d = bus_wdata & TIMING_WMASK;
    if (wr_vid) vid_d = bus_wdata;
    if (wr_dia) dia_d = bus_wdata;
    if (wr_ev0) ev0_d = bus_wdata;
    if (wr_ev1) ev1_d = bus_wdata;
    if (flt_load) begin
      fst_d = flt_status;
      flo_d = flt_addr_lo;
      fhi_d = flt_addr_hi;
    end else if (wr_fst) begin
      fst_d = bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tim_q <= TIMING_RST;
      fst_q <= '0;
      vid_q <= '0;
      flo_q <= FADDR_LO_RST;
      fhi_q <= '0;
      dia_q <= '0;
      ev0_q <= '0;
      ev1_q <= '0;
    end else begin
      tim_q <= tim_d;
      fst_q <= fst_d;
      vid_q <= vid_d;
      flo_q <= flo_d;
      fhi_q <= fhi_d;
      dia_q <= dia_d;
      ev0_q <= ev0_d;
      ev1_q <= ev1_d;
    end

  // Read path
  logic [DATA_W-1:0] main_rdata;
  logic [3:0]        impl_code;

  assign impl_code = 4'(IMPL);

  always_comb begin
    main_rdata = '0;
    if (rd_hit) begin
      case (rd_ix)
        IXW'(REG_ENABLE):   main_rdata = {impl_code, 4'h0, 12'h000, ctl_q};
        IXW'(REG_TIMING):   main_rdata = tim_q;
        IXW'(REG_FSTAT):    main_rdata = fst_q;
        IXW'(REG_VIDEO):    main_rdata = vid_q;
        IXW'(REG_FADDR_LO): main_rdata = flo_q;
        IXW'(REG_FADDR_HI): main_rdata = fhi_q;
        IXW'(REG_DIAG):     main_rdata = dia_q;
        IXW'(REG_EVCNT0):   main_rdata = ev0_q;
        IXW'(REG_EVCNT1):   main_rdata = ev1_q;
        default:            main_rdata = '0;
      endcase
    end
  end

  assign bus_rdata = bus_sel ? main_rdata : diag_rdata;

  assert_tim_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tim |=> (tim_q == {1'b0, $past(bus_wdata[30:0])}));
  assert_fault_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    flt_load |=> (fst_q == $past(flt_status)) && (flo_q == $past(flt_addr_lo)) &&
                 (fhi_q == $past(flt_addr_hi)));
  assert_faddr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !flt_load |=> $stable(flo_q) && $stable(fhi_q));
  assert_ev_indep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_we && bus_word && bus_addr == ADDR_W'(4 * REG_EVCNT1)) |=> $stable(ev0_q));
endmodule

// File: tb/ecc_ctl_regs_tb.sv
`timescale 1ns/1ps
module ecc_ctl_regs_tb_top;

  localparam int NV = 12;
  // {addr[5:0], wdata, expect impl0, expect impl1}
  localparam logic [101:0] VECS [NV] = '{
    {6'h00, 32'hFFFF_FFFF, 32'h0000_0103, 32'h1000_0BFF}, // R1
    {6'h04, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h7FFF_FFFF}, // R3
    {6'h0C, 32'hA5A5_5A5A, 32'hA5A5_5A5A, 32'hA5A5_5A5A}, // R4 video
    {6'h18, 32'h1234_5678, 32'h1234_5678, 32'h1234_5678}, // R4 diagnostic
    {6'h1C, 32'h1111_1111, 32'h1111_1111, 32'h1111_1111}, // R10
    {6'h20, 32'h2222_2222, 32'h2222_2222, 32'h2222_2222}, // R10
    {6'h10, 32'hFFFF_FFFF, 32'h07C0_0000, 32'h07C0_0000}, // R8
    {6'h14, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000}, // R8
    {6'h24, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000}, // R8
    {6'h3C, 32'hFFFF_FFFF, 32'h0000_0000, 32'h0000_0000}, // R8
    {6'h00, 32'h0000_0000, 32'h0000_0000, 32'h1000_0000}, // R1
    {6'h04, 32'h8000_0001, 32'h0000_0001, 32'h0000_0001}  // R3
  };
  localparam int VTAG [NV] = '{1, 3, 4, 4, 10, 10, 8, 8, 8, 8, 1, 3};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, diag_sel, bus_we, bus_word;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, rdata0, rdata1;
  logic        flt_load;
  logic [31:0] flt_status, flt_addr_lo, flt_addr_hi;
  logic        irq0, irq1;
  logic [31:0] rd0, rd1;
  int          nchk = 0;
  int          nerr = 0;

  always #2.5 clk = ~clk;

  ecc_ctl_regs #(.IMPL(0), .ADDR_W(6)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .diag_sel(diag_sel),
    .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata0), .flt_load(flt_load),
    .flt_status(flt_status), .flt_addr_lo(flt_addr_lo),
    .flt_addr_hi(flt_addr_hi), .irq(irq0));

  ecc_ctl_regs #(.IMPL(1), .ADDR_W(6)) dut_e (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .diag_sel(diag_sel),
    .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(rdata1), .flt_load(flt_load),
    .flt_status(flt_status), .flt_addr_lo(flt_addr_lo),
    .flt_addr_hi(flt_addr_hi), .irq(irq1));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic m, input logic d, input logic w,
                           input logic [5:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_sel = m; diag_sel = d; bus_we = 1'b1; bus_word = w; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_sel = 1'b0; diag_sel = 1'b0; bus_we = 1'b0; bus_word = 1'b1;
  endtask

  task automatic bus_read(input logic m, input logic d, input logic w, input logic [5:0] a);
    @(negedge clk);
    bus_sel = m; diag_sel = d; bus_we = 1'b0; bus_word = w; bus_addr = a;
    #1;
    rd0 = rdata0; rd1 = rdata1;
    bus_sel = 1'b0; diag_sel = 1'b0; bus_word = 1'b1;
  endtask

  task automatic fault(input logic [31:0] st, input logic [31:0] lo, input logic [31:0] hi);
    @(negedge clk);
    flt_load = 1'b1; flt_status = st; flt_addr_lo = lo; flt_addr_hi = hi;
    @(negedge clk);
    flt_load = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 100000);
    nerr++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; diag_sel = 1'b0; bus_we = 1'b0; bus_word = 1'b1;
    bus_addr = '0; bus_wdata = '0; flt_load = 1'b0;
    flt_status = '0; flt_addr_lo = '0; flt_addr_hi = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // Reset state: R4, R3, R2 (non-retained control bits)
    bus_read(1, 0, 1, 6'h00);
    check("R2 reset ctl impl0", rd0 & ~32'h0000_0100, 32'h0);
    check("R2 reset ctl impl1", rd1 & ~32'h0000_0BFC, 32'h1000_0000);
    bus_read(1, 0, 1, 6'h04); check("R3 reset timing", rd0, 32'h20);
    bus_read(1, 0, 1, 6'h08); check("R4 reset fstat", rd1, 32'h0);
    bus_read(1, 0, 1, 6'h10); check("R4 reset faddr lo", rd0, 32'h07C0_0000);
    bus_read(1, 0, 1, 6'h20); check("R4 reset evcnt1", rd1, 32'h0);
    check("R4 reset irq", {30'b0, irq1, irq0}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      bus_write(1, 0, 1, VECS[i][101:96], VECS[i][95:64]);
      bus_read(1, 0, 1, VECS[i][101:96]);
      check($sformatf("R%0d vec%0d impl0", VTAG[i], i), rd0, VECS[i][63:32]);
      check($sformatf("R%0d vec%0d impl1", VTAG[i], i), rd1, VECS[i][31:0]);
    end

    // R10: event counter 0 unaffected by the counter 1 write
    bus_read(1, 0, 1, 6'h1C); check("R10 evcnt0 kept", rd0, 32'h1111_1111);

    // R9: byte and misaligned accesses do nothing in the main window
    bus_write(1, 0, 0, 6'h0C, 32'h0);
    bus_write(1, 0, 1, 6'h0D, 32'h0);
    bus_read(1, 0, 1, 6'h0C); check("R9 video unchanged", rd0, 32'hA5A5_5A5A);
    bus_read(1, 0, 0, 6'h0C); check("R9 byte read zero", rd1, 32'h0);

    // R6 capture, R7 correctable masked
    fault(32'h1, 32'hCAFE_0001, 32'h55);
    check("R7 ce masked", {30'b0, irq1, irq0}, 32'h0);
    bus_read(1, 0, 1, 6'h08); check("R6 fstat loaded", rd0, 32'h1);
    bus_read(1, 0, 1, 6'h10); check("R6 faddr lo loaded", rd1, 32'hCAFE_0001);
    bus_read(1, 0, 1, 6'h14); check("R6 faddr hi loaded", rd0, 32'h55);

    // R7 correctable enabled
    bus_write(1, 0, 1, 6'h00, 32'h2);
    bus_read(1, 0, 1, 6'h00); check("R1 ceirq enable impl1", rd1, 32'h1000_0002);
    fault(32'h1, 32'h0, 32'h0);
    check("R7 ce enabled", {30'b0, irq1, irq0}, 32'h3);

    // R5 fstat write clears irq and stores full word
    bus_write(1, 0, 1, 6'h08, 32'hDEAD_BEEF);
    check("R5 irq cleared", {30'b0, irq1, irq0}, 32'h0);
    bus_read(1, 0, 1, 6'h08); check("R5 fstat full", rd0, 32'hDEAD_BEEF);

    // R7 uncorrectable always raises
    bus_write(1, 0, 1, 6'h00, 32'h0);
    fault(32'h8, 32'h0, 32'h0);
    check("R7 ue raises", {30'b0, irq1, irq0}, 32'h3);
    bus_write(1, 0, 1, 6'h08, 32'h0);

    // R6 capture wins over simultaneous fstat write
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_word = 1'b1; bus_addr = 6'h08; bus_wdata = 32'h0;
    flt_load = 1'b1; flt_status = 32'h8;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; flt_load = 1'b0;
    check("R6 capture priority irq", {30'b0, irq1, irq0}, 32'h3);
    bus_read(1, 0, 1, 6'h08); check("R6 capture priority fstat", rd1, 32'h8);

    // R11 / R12 diagnostic window
    bus_write(0, 1, 0, 6'h01, 32'h0000_00AB);
    bus_read(0, 1, 0, 6'h01);
    check("R11 diag byte1", rd0, 32'hAB);
    check("R12 no diag impl1", rd1, 32'h0);
    bus_read(0, 1, 0, 6'h00); check("R11 diag byte0", rd0, 32'h0);
    bus_write(0, 1, 1, 6'h02, 32'hFFFF_FFFF);
    bus_read(0, 1, 0, 6'h02); check("R11 word access ignored", rd0, 32'h0);

    // R2 retention across reset
    bus_write(1, 0, 1, 6'h00, 32'hFFFF_FFFF);
    do_reset();
    bus_read(1, 0, 1, 6'h00);
    check("R2 retain impl0", rd0, 32'h0000_0100);
    check("R2 retain impl1", rd1, 32'h1000_0BFC);
    bus_read(1, 0, 1, 6'h0C); check("R4 video after reset", rd0, 32'h0);
    check("R4 irq after reset", {30'b0, irq1, irq0}, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule